// File: doc/BRIEF.md
# Flit Class Steering Stage

This block sits at one input port of an on-chip network switch. It takes in a stream of flits. Each flit is tagged with a 2-bit kind: idle, header, data or end-of-packet. When a header flit arrives, the block reads the service class carried in it and remembers that class. It then sends the header, and every flit of the same packet up to and including the end-of-packet flit, into a FIFO kept only for that class.

There are four class FIFOs. Each one offers a valid/ready read port to a downstream scheduler, and each read port carries the flit kind with the payload so that the scheduler can see packet boundaries. Input backpressure is a single ready signal. It falls only when the FIFO that the current flit would go to is full.

A data or end-of-packet flit that arrives with no packet open is thrown away, and a sticky error flag is raised. The classifier takes one clock cycle. A flit accepted on one edge shows up at its queue head right after that edge, and it can be popped on the next edge at the earliest.

Top module: `flit_class_steer`

## Requirements
- R1: The kind field `in_kind_i` is encoded as 00 idle, 01 header, 10 data and 11 end-of-packet. An idle flit is always accepted and changes no FIFO occupancy.
- R2: An accepted header flit is written into the FIFO whose index equals its 2-bit class field `in_cls_i`, where class 0 is the highest priority. That class is then held as the open packet's class.
- R3: An accepted data or end-of-packet flit of an open packet is written into the FIFO of the held class. The class field on that flit is ignored.
- R4: Accepting an end-of-packet flit closes the packet. A data flit that follows it is dropped as an orphan.
- R5: A data or end-of-packet flit presented with no open packet is accepted (ready high), written nowhere, and sets `err_o`. Only reset clears `err_o`.
- R6: `in_ready_o` is low exactly when the flit is a header whose class FIFO is full, or a data or end-of-packet flit of an open packet whose held-class FIFO is full. A flit is taken only when valid and ready are both high.
- R7: A flit accepted at clock edge k is visible at the head of its class FIFO right after edge k, and it can be popped no earlier than edge k+1. Each FIFO keeps arrival order and returns the kind and payload unchanged.
- R8: Each `q_count_o` lane reports the occupancy of its FIFO, from 0 up to DEPTH (8 by default).
- R9: After reset all FIFOs are empty, `err_o` is 0, no packet is open, and `in_ready_o` is high.
- R10: A full FIFO of one class does not block a header bound for another class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input flit valid |
| in_ready_o | output | 1 | Input flit accepted when high with valid |
| in_kind_i | input | 2 | Flit kind: 00 idle, 01 header, 10 data, 11 end-of-packet |
| in_cls_i | input | 2 | Service class, used on header flits only |
| in_data_i | input | DATA_W | Flit payload |
| q_valid_o | output | 4 | Per-class head valid |
| q_ready_i | input | 4 | Per-class pop request |
| q_kind_o | output | 8 | Per-class head kind, 2 bits per lane, lane c at [2c+1:2c] |
| q_data_o | output | 4*DATA_W | Per-class head payload, lane c at [c*DATA_W +: DATA_W] |
| q_count_o | output | 4*CNT_W | Per-class occupancy, CNT_W = clog2(DEPTH+1) bits per lane |
| err_o | output | 1 | Sticky orphan-flit error |

## Verification
The assertions are checked on every cycle. They cover these rules: at most one FIFO is written per cycle, and never a full one. The held class does not change in the middle of a packet. The error flag stays set once raised. A queue head appears only after a write, and a count never goes above the depth.

Only the bench's scenarios can show the rest. That includes whether a packet's flits end up in the class named by its header, whether an orphan is dropped rather than stored, and whether the payload order matches. It also includes the backpressure value on each cycle and the independence of the classes when one of them fills up. The bench checks these by comparing the ports against a reference model of four queues on every cycle.

// File: rtl/flit_pkg.sv
package flit_pkg;
  localparam int unsigned CLS_W   = 2;
  localparam int unsigned NUM_CLS = 1 << CLS_W;
  localparam int unsigned KIND_W  = 2;

  typedef enum logic [KIND_W-1:0] {
    FK_IDLE = 2'b00,
    FK_HEAD = 2'b01,
    FK_BODY = 2'b10,
    FK_TAIL = 2'b11
  } flit_kind_e;
endpackage

// File: rtl/flit_classifier.sv
module flit_classifier
  import flit_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [KIND_W-1:0]  kind_i,
  input  logic [CLS_W-1:0]   cls_i,
  input  logic [NUM_CLS-1:0] full_i,
  output logic               ready_o,
  output logic [NUM_CLS-1:0] wr_en_o,
  output logic               err_o
);
  logic             open_q;
  logic [CLS_W-1:0] cls_q;
  logic             err_q;
  logic [CLS_W-1:0] target;
  logic             steer;
  logic             orphan;
  logic             take;

  always_comb begin
    target = cls_q;
    steer  = 1'b0;
    orphan = 1'b0;
    unique case (flit_kind_e'(kind_i))
      FK_HEAD: begin
        target = cls_i;
        steer  = 1'b1;
      end
      FK_BODY, FK_TAIL: begin
        steer  = open_q;
        orphan = !open_q;
      end
      default: ;
    endcase
  end

  assign ready_o = !(steer && full_i[target]);
  assign take    = valid_i && ready_o;

  always_comb begin
    wr_en_o = '0;
    if (take && steer) wr_en_o[target] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      cls_q  <= '0;
      err_q  <= 1'b0;
    end else if (take) begin
      if (flit_kind_e'(kind_i) == FK_HEAD) begin
        open_q <= 1'b1;
        cls_q  <= cls_i;
      end else if (flit_kind_e'(kind_i) == FK_TAIL && open_q) begin
        open_q <= 1'b0;
      end
      if (orphan) err_q <= 1'b1;
    end
  end

  assign err_o = err_q;

  a_r2_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o));
  a_r6_no_write_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o & full_i) == '0);
  a_r3_class_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_q && !(take && flit_kind_e'(kind_i) == FK_HEAD)) |=> $stable(cls_q));
  a_r5_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: rtl/class_fifo.sv
module class_fifo #(
  parameter int unsigned DW    = 34,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign valid_o = (cnt_q != '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i && valid_o;
  assign data_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= bump(wr_ptr_q);
      if (do_pop) rd_ptr_q <= bump(rd_ptr_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(do_pop);
    end
  end

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r7_head_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(push_i));
  a_r8_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
  a_r7_head_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !pop_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/flit_class_steer.sv
module flit_class_steer
  import flit_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned ENT_W = KIND_W + DATA_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       in_valid_i,
  output logic                       in_ready_o,
  input  logic [KIND_W-1:0]          in_kind_i,
  input  logic [CLS_W-1:0]           in_cls_i,
  input  logic [DATA_W-1:0]          in_data_i,
  output logic [NUM_CLS-1:0]         q_valid_o,
  input  logic [NUM_CLS-1:0]         q_ready_i,
  output logic [NUM_CLS*KIND_W-1:0]  q_kind_o,
  output logic [NUM_CLS*DATA_W-1:0]  q_data_o,
  output logic [NUM_CLS*CNT_W-1:0]   q_count_o,
  output logic                       err_o
);
  logic [NUM_CLS-1:0] full;
  logic [NUM_CLS-1:0] wr_en;

  flit_classifier u_cls (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .kind_i  (in_kind_i),
    .cls_i   (in_cls_i),
    .full_i  (full),
    .ready_o (in_ready_o),
    .wr_en_o (wr_en),
    .err_o   (err_o)
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_q
    logic [ENT_W-1:0] head;
    class_fifo #(.DW(ENT_W), .DEPTH(DEPTH)) u_fifo (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (wr_en[c]),
      .push_data_i ({in_kind_i, in_data_i}),
      .pop_i       (q_ready_i[c]),
      .valid_o     (q_valid_o[c]),
      .data_o      (head),
      .count_o     (q_count_o[c*CNT_W +: CNT_W]),
      .full_o      (full[c])
    );
    assign q_kind_o[c*KIND_W +: KIND_W] = head[ENT_W-1 -: KIND_W];
    assign q_data_o[c*DATA_W +: DATA_W] = head[DATA_W-1:0];
  end
endmodule

// File: tb/flit_class_steer_bench.sv
`timescale 1ns/1ps
module flit_class_steer_bench;
  localparam int DW = 32;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int NQ = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_kind = 2'b00;
  logic [1:0] in_cls = 2'b00;
  logic [DW-1:0] in_data = '0;
  logic [NQ-1:0] q_valid;
  logic [NQ-1:0] q_ready = '0;
  logic [NQ*2-1:0] q_kind;
  logic [NQ*DW-1:0] q_data;
  logic [NQ*CW-1:0] q_count;
  logic err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [DW+1:0] mq [NQ][$];
  bit m_open = 1'b0;
  int m_cls = 0;
  bit m_err = 1'b0;

  always #2 clk = ~clk;

  flit_class_steer #(.DATA_W(DW), .DEPTH(DEPTH)) u_flit_class_steer (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_kind_i(in_kind), .in_cls_i(in_cls), .in_data_i(in_data),
    .q_valid_o(q_valid), .q_ready_i(q_ready), .q_kind_o(q_kind),
    .q_data_o(q_data), .q_count_o(q_count), .err_o(err)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit exp_ready(input logic [1:0] k, input logic [1:0] c);
    case (k)
      2'b01: return mq[c].size() < DEPTH;
      2'b10, 2'b11: return m_open ? (mq[m_cls].size() < DEPTH) : 1'b1;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int cnt(input int q);
    return int'(q_count[q*CW +: CW]);
  endfunction

  // drive at negedge, check before posedge, update model after posedge
  task automatic step(input bit v, input logic [1:0] k, input logic [1:0] c,
                      input logic [DW-1:0] d, input logic [NQ-1:0] qr);
    bit acc;
    in_valid = v; in_kind = k; in_cls = c; in_data = d; q_ready = qr;
    #1;
    chk("R6 ready", in_ready, exp_ready(k, c));
    chk("R5 err", err, m_err);
    for (int q = 0; q < NQ; q++) begin
      chk("R8 count", cnt(q), mq[q].size());
      chk("R7 valid", q_valid[q], mq[q].size() > 0);
      if (mq[q].size() > 0) begin
        chk("R2 R3 R7 head", {q_kind[q*2 +: 2], q_data[q*DW +: DW]}, mq[q][0]);
      end
    end
    acc = v && exp_ready(k, c);
    @(posedge clk);
    for (int q = 0; q < NQ; q++) begin
      if (qr[q] && mq[q].size() > 0) void'(mq[q].pop_front());
    end
    if (acc) begin
      case (k)
        2'b01: begin mq[c].push_back({k, d}); m_open = 1'b1; m_cls = c; end
        2'b10, 2'b11: begin
          if (m_open) begin
            mq[m_cls].push_back({k, d});
            if (k == 2'b11) m_open = 1'b0;
          end else m_err = 1'b1;
        end
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R9 ready", in_ready, 1);
    chk("R9 err", err, 0);
    chk("R9 valid", q_valid, 0);
    chk("R9 count", q_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    step(1, 2'b00, 2'd1, 32'h11, '0);
    chk("R1 idle no write", q_count, 0);
    step(1, 2'b01, 2'd2, 32'hA0, '0);
    chk("R2 header to class 2", cnt(2), 1);
    chk("R7 visible after one edge", q_valid[2], 1);
    step(1, 2'b10, 2'd0, 32'hA1, '0);
    chk("R3 data follows held class", cnt(2), 2);
    chk("R3 class field ignored", cnt(0), 0);
    step(1, 2'b11, 2'd1, 32'hA2, '0);
    chk("R3 tail follows held class", cnt(2), 3);
    step(1, 2'b10, 2'd2, 32'hA3, '0);
    chk("R4 data after tail dropped", cnt(2), 3);
    chk("R4 R5 err set", err, 1);
    step(1, 2'b01, 2'd2, 32'hB0, '0);
    for (int i = 0; i < 4; i++) step(1, 2'b10, 2'd3, 32'hB1 + i, '0);
    chk("R8 full count", cnt(2), DEPTH);
    step(1, 2'b10, 2'd2, 32'hBF, '0);
    chk("R6 stalled count", cnt(2), DEPTH);
    step(0, 2'b10, 2'd2, 32'hBF, '0);
    #1;
    chk("R6 ready low on full", in_ready, 0);
    in_kind = 2'b01; in_cls = 2'd0; #0.5;
    chk("R10 other class ready", in_ready, 1);
    @(negedge clk);
    step(1, 2'b01, 2'd0, 32'hC0, '0);
    chk("R10 header other class", cnt(0), 1);
    step(1, 2'b11, 2'd0, 32'hC1, 4'b0100);
    chk("R7 pop one", cnt(2), DEPTH - 1);
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      logic [1:0] k = (r < 10) ? 2'b00 : (r < 35) ? 2'b01 : (r < 85) ? 2'b10 : 2'b11;
      logic [NQ-1:0] qr = ((i / 500) % 2 == 0) ? NQ'($urandom() & $urandom())
                                               : NQ'($urandom() | $urandom());
      step($urandom_range(0, 3) != 0, k, 2'($urandom()), $urandom(), qr);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule